// File: doc/BRIEF.md
# VLAN Membership Table Engine

This block holds a small set of VLAN records for an Ethernet switch. Each record pairs a 12-bit VLAN identifier with a ten-bit mask of member ports. Software manages the set through two 32-bit command words. It writes the operand word, then writes the command word with its busy bit set. The engine executes one of five table functions and drops busy when the work is done. The functions are a full clear, load, purge, removal of one port from every record, and an ordered walk.

Forwarding logic elsewhere in the chip queries the table through a combinational lookup port. The port returns the member mask and a hit flag for any identifier. A load that finds no matching record and no free slot leaves the table untouched and raises a sticky violation flag.

Top module: `vlan_member_table`

## Requirements
- R1: After reset every record is invalid, both command words read as zero and the lookup port reports a miss with a zero mask for every identifier.
- R2: Writing the command word (select 0) with bit 3 set starts the function held in bits [2:0]. Bit 3 reads 1 on the cycle after that write and 0 on the following cycle. Writes to either word while bit 3 reads 1 are ignored. The VLAN identifier field (bits [27:16]), the priority enable (bit 31) and the priority (bits [30:28]) read back as written.
- R3: Function 2 (load) stores the identifier from command bits [27:16] with the mask from operand word (select 1) bits [9:0]. From the cycle on which busy reads 0, the lookup port returns that mask with the hit flag set.
- R4: A load to an identifier already stored replaces its mask and takes no further slot.
- R5: Identifier 0 is never stored. A load of it changes nothing, and a lookup of it always misses.
- R6: A load of a new identifier while all 16 slots are valid leaves the table unchanged and sets command bit 4. That bit stays set through any write other than an all-zero write to the command word, which clears it.
- R7: Function 3 (purge) invalidates the record with the given identifier and leaves all others unchanged.
- R8: Function 1 invalidates every record.
- R9: Function 4 takes a port number from command bits [11:8] and clears that bit in the mask of every valid record. It invalidates each record whose mask becomes zero. A port number of 10 or more has no effect.
- R10: Function 5 finds the valid record with the smallest identifier greater than the one in command bits [27:16]. It writes that identifier back into those bits and sets the operand word to bit 11 = 1 with the record's mask in bits [9:0]. When no such record exists, the operand word becomes zero and the identifier is unchanged.
- R11: Function 0 and any unused function code leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Write strobe for a command word |
| cfg_wr_sel | input | 1 | Word select for writes: 0 command word, 1 operand word |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | 1 | Word select for reads: 0 command word, 1 operand word |
| cfg_rd_data | output | 32 | Read data of the selected word |
| lk_vid | input | 12 | Identifier to look up |
| lk_hit | output | 1 | A valid record holds lk_vid |
| lk_mask | output | 10 | Member mask of that record, zero on a miss |

## Verification
Directed sequences cover the cases that only a specific order exposes:
- filling all sixteen slots and then loading a seventeenth identifier, which separates replacement from allocation and shows the sticky flag;
- port removal that empties one record but only trims another;
- a walk that starts above the largest stored identifier;
- an intruding write during the busy cycle.

A seeded random stream then mixes every function over a narrow identifier range, so collisions, refills after purges and repeated overflow are frequent. After each command the lookup result, the violation flag and the walk result are compared with a set-based model. The model has no notion of slot order, so a wrong slot choice shows up only as a wrong mask or a wrong membership.

// File: rtl/vmt_pkg.sv
package vmt_pkg;
  localparam int VID_W  = 12;
  localparam int MASK_W = 10;
  localparam int PORT_W = 4;
  localparam int FN_W   = 3;
  localparam int PRI_W  = 3;

  // command word bit positions (software-visible layout)
  localparam int W0_FN_LO   = 0;
  localparam int W0_BUSY    = 3;
  localparam int W0_FULL    = 4;
  localparam int W0_PORT_LO = 8;
  localparam int W0_VID_LO  = 16;
  localparam int W0_PRI_LO  = 28;
  localparam int W0_PRI_EN  = 31;
  // operand word bit positions
  localparam int W1_VALID   = 11;

  typedef enum logic [FN_W-1:0] {
    FN_NOP       = 3'd0,
    FN_FLUSH     = 3'd1,
    FN_LOAD      = 3'd2,
    FN_PURGE     = 3'd3,
    FN_DROP_PORT = 3'd4,
    FN_NEXT      = 3'd5
  } vmt_fn_e;
endpackage

// File: rtl/vmt_match.sv
module vmt_match
  import vmt_pkg::*;
#(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            ent_valid,
  input  logic [N-1:0][VID_W-1:0] ent_vid,
  input  logic [VID_W-1:0]        key,
  output logic [N-1:0]            hit_vec,
  output logic                    hit,
  output logic [IW-1:0]           idx
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = ent_valid[g] && (ent_vid[g] == key);
    end
  endgenerate

  always_comb begin
    hit = |hit_vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vmt_next.sv
module vmt_next
  import vmt_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]             ent_valid,
  input  logic [N-1:0][VID_W-1:0]  ent_vid,
  input  logic [N-1:0][MASK_W-1:0] ent_mask,
  input  logic [VID_W-1:0]         base_vid,
  output logic                     found,
  output logic [VID_W-1:0]         nx_vid,
  output logic [MASK_W-1:0]        nx_mask
);
  // smallest stored identifier strictly above base_vid
  always_comb begin
    found   = 1'b0;
    nx_vid  = '0;
    nx_mask = '0;
    for (int i = 0; i < N; i++) begin
      if (ent_valid[i] && (ent_vid[i] > base_vid) &&
          (!found || (ent_vid[i] < nx_vid))) begin
        found   = 1'b1;
        nx_vid  = ent_vid[i];
        nx_mask = ent_mask[i];
      end
    end
  end
endmodule

// File: rtl/vmt_store.sv
module vmt_store
  import vmt_pkg::*;
#(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  vmt_fn_e                  fn,
  input  logic [VID_W-1:0]         cmd_vid,
  input  logic [PORT_W-1:0]        cmd_port,
  input  logic [MASK_W-1:0]        cmd_mask,
  output logic [N-1:0]             ent_valid,
  output logic [N-1:0][VID_W-1:0]  ent_vid,
  output logic [N-1:0][MASK_W-1:0] ent_mask,
  output logic                     load_full
);
  logic [N-1:0]      hit_vec;
  logic              cmd_hit;
  logic [IW-1:0]     cmd_idx;
  logic              free_hit;
  logic [IW-1:0]     free_idx;
  logic              vid_nz;
  logic              tbl_en;
  logic [MASK_W-1:0] port_bit;

  vmt_match #(.N(N)) u_cmd_match (
    .ent_valid (ent_valid),
    .ent_vid   (ent_vid),
    .key       (cmd_vid),
    .hit_vec   (hit_vec),
    .hit       (cmd_hit),
    .idx       (cmd_idx)
  );

  // lowest free slot
  always_comb begin
    free_hit = ~&ent_valid;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_idx = IW'(i);
    end
  end

  genvar p;
  generate
    for (p = 0; p < MASK_W; p++) begin : g_pbit
      assign port_bit[p] = (cmd_port == PORT_W'(p));
    end
  endgenerate

  assign vid_nz    = (cmd_vid != '0);
  assign load_full = go && (fn == FN_LOAD) && vid_nz && !cmd_hit && !free_hit;
  assign tbl_en    = go && ((fn == FN_FLUSH) || (fn == FN_LOAD) ||
                            (fn == FN_PURGE) || (fn == FN_DROP_PORT));

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_slot
      logic              v_q, v_d;
      logic [VID_W-1:0]  id_q, id_d;
      logic [MASK_W-1:0] m_q, m_d;
      logic              is_mine, is_free;

      assign is_mine = cmd_hit && (cmd_idx == IW'(g));
      assign is_free = !cmd_hit && free_hit && (free_idx == IW'(g));

      always_comb begin
        v_d  = v_q;
        id_d = id_q;
        m_d  = m_q;
        unique case (fn)
          FN_FLUSH: v_d = 1'b0;
          FN_LOAD: begin
            if (vid_nz && is_mine) begin
              m_d = cmd_mask;
            end else if (vid_nz && is_free) begin
              v_d  = 1'b1;
              id_d = cmd_vid;
              m_d  = cmd_mask;
            end
          end
          FN_PURGE: if (is_mine) v_d = 1'b0;
          FN_DROP_PORT: begin
            if (v_q && (|port_bit)) begin
              m_d = m_q & ~port_bit;
              if (m_d == '0) v_d = 1'b0;
            end
          end
          default: ;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q  <= 1'b0;
          id_q <= '0;
          m_q  <= '0;
        end else if (tbl_en) begin
          v_q  <= v_d;
          id_q <= id_d;
          m_q  <= m_d;
        end
      end

      assign ent_valid[g] = v_q;
      assign ent_vid[g]   = id_q;
      assign ent_mask[g]  = m_q;

      AST_NO_VID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        v_q |-> (id_q != '0)); // R5
    end
  endgenerate

  AST_UNIQUE_VID: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R4

  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> ($stable(ent_valid) && $stable(ent_mask))); // R11

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (fn == FN_FLUSH)) |=> (ent_valid == '0)); // R8
endmodule

// File: rtl/vmt_regs.sv
module vmt_regs
  import vmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              rd_sel,
  output logic [31:0]       rd_data,
  input  logic              load_full,
  input  logic              nx_found,
  input  logic [VID_W-1:0]  nx_vid,
  input  logic [MASK_W-1:0] nx_mask,
  output logic              go,
  output vmt_fn_e           fn,
  output logic [VID_W-1:0]  cmd_vid,
  output logic [PORT_W-1:0] cmd_port,
  output logic [MASK_W-1:0] cmd_mask
);
  logic              pri_en_q, pri_en_d;
  logic [PRI_W-1:0]  pri_q, pri_d;
  logic [VID_W-1:0]  vid_q, vid_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic              full_q, full_d;
  logic              busy_q, busy_d;
  logic [FN_W-1:0]   fn_q, fn_d;
  logic              w1v_q, w1v_d;
  logic [MASK_W-1:0] w1m_q, w1m_d;
  logic              reg_en;
  logic              unused_bits;

  assign unused_bits = ^{wr_data[15:12], wr_data[7:5], wr_data[31:12], wr_data[10]};
  assign reg_en      = busy_q || wr_en;

  always_comb begin
    pri_en_d = pri_en_q;
    pri_d    = pri_q;
    vid_d    = vid_q;
    port_d   = port_q;
    full_d   = full_q;
    busy_d   = busy_q;
    fn_d     = fn_q;
    w1v_d    = w1v_q;
    w1m_d    = w1m_q;
    if (busy_q) begin
      busy_d = 1'b0;
      if (load_full) full_d = 1'b1;
      if (fn_q == FN_NEXT) begin
        if (nx_found) begin
          vid_d = nx_vid;
          w1v_d = 1'b1;
          w1m_d = nx_mask;
        end else begin
          w1v_d = 1'b0;
          w1m_d = '0;
        end
      end
    end else if (wr_en) begin
      if (!wr_sel) begin
        pri_en_d = wr_data[W0_PRI_EN];
        pri_d    = wr_data[W0_PRI_LO +: PRI_W];
        vid_d    = wr_data[W0_VID_LO +: VID_W];
        port_d   = wr_data[W0_PORT_LO +: PORT_W];
        busy_d   = wr_data[W0_BUSY];
        fn_d     = wr_data[W0_FN_LO +: FN_W];
        if (wr_data == '0) full_d = 1'b0;
      end else begin
        w1v_d = wr_data[W1_VALID];
        w1m_d = wr_data[MASK_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_en_q <= 1'b0;
      pri_q    <= '0;
      vid_q    <= '0;
      port_q   <= '0;
      full_q   <= 1'b0;
      busy_q   <= 1'b0;
      fn_q     <= '0;
      w1v_q    <= 1'b0;
      w1m_q    <= '0;
    end else if (reg_en) begin
      pri_en_q <= pri_en_d;
      pri_q    <= pri_d;
      vid_q    <= vid_d;
      port_q   <= port_d;
      full_q   <= full_d;
      busy_q   <= busy_d;
      fn_q     <= fn_d;
      w1v_q    <= w1v_d;
      w1m_q    <= w1m_d;
    end
  end

  assign go       = busy_q;
  assign fn       = vmt_fn_e'(fn_q);
  assign cmd_vid  = vid_q;
  assign cmd_port = port_q;
  assign cmd_mask = w1m_q;

  always_comb begin
    if (!rd_sel) begin
      rd_data = {pri_en_q, pri_q, vid_q, 4'b0, port_q, 3'b0,
                 full_q, busy_q, fn_q};
    end else begin
      rd_data = {20'b0, w1v_q, 1'b0, w1m_q};
    end
  end

  AST_BUSY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q); // R2

  AST_WR_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (fn_q != FN_NEXT)) |=> ($stable(vid_q) && $stable(w1m_q) && $stable(port_q))); // R2

  AST_FULL_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> ($past(busy_q) && ($past(fn_q) == FN_LOAD))); // R6

  AST_NEXT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (fn_q == FN_NEXT) && nx_found) |=> (vid_q > $past(vid_q))); // R10
endmodule

// File: rtl/vlan_member_table.sv
module vlan_member_table
  import vmt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_wr_sel,
  input  logic [31:0]       cfg_wr_data,
  input  logic              cfg_rd_sel,
  output logic [31:0]       cfg_rd_data,
  input  logic [VID_W-1:0]  lk_vid,
  output logic              lk_hit,
  output logic [MASK_W-1:0] lk_mask
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                               go;
  vmt_fn_e                            fn;
  logic [VID_W-1:0]                   cmd_vid;
  logic [PORT_W-1:0]                  cmd_port;
  logic [MASK_W-1:0]                  cmd_mask;
  logic                               load_full;
  logic                               nx_found;
  logic [VID_W-1:0]                   nx_vid;
  logic [MASK_W-1:0]                  nx_mask;
  logic [NUM_ENTRIES-1:0]             ent_valid;
  logic [NUM_ENTRIES-1:0][VID_W-1:0]  ent_vid;
  logic [NUM_ENTRIES-1:0][MASK_W-1:0] ent_mask;
  logic [NUM_ENTRIES-1:0]             lk_vec;
  logic [IW-1:0]                      lk_idx;

  vmt_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (cfg_wr_en),
    .wr_sel    (cfg_wr_sel),
    .wr_data   (cfg_wr_data),
    .rd_sel    (cfg_rd_sel),
    .rd_data   (cfg_rd_data),
    .load_full (load_full),
    .nx_found  (nx_found),
    .nx_vid    (nx_vid),
    .nx_mask   (nx_mask),
    .go        (go),
    .fn        (fn),
    .cmd_vid   (cmd_vid),
    .cmd_port  (cmd_port),
    .cmd_mask  (cmd_mask)
  );

  vmt_store #(.N(NUM_ENTRIES)) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .go        (go),
    .fn        (fn),
    .cmd_vid   (cmd_vid),
    .cmd_port  (cmd_port),
    .cmd_mask  (cmd_mask),
    .ent_valid (ent_valid),
    .ent_vid   (ent_vid),
    .ent_mask  (ent_mask),
    .load_full (load_full)
  );

  vmt_next #(.N(NUM_ENTRIES)) u_next (
    .ent_valid (ent_valid),
    .ent_vid   (ent_vid),
    .ent_mask  (ent_mask),
    .base_vid  (cmd_vid),
    .found     (nx_found),
    .nx_vid    (nx_vid),
    .nx_mask   (nx_mask)
  );

  vmt_match #(.N(NUM_ENTRIES)) u_lk_match (
    .ent_valid (ent_valid),
    .ent_vid   (ent_vid),
    .key       (lk_vid),
    .hit_vec   (lk_vec),
    .hit       (lk_hit),
    .idx       (lk_idx)
  );

  assign lk_mask = lk_hit ? ent_mask[lk_idx] : '0;

  AST_LK_ZERO_MISS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lk_vid == '0) |-> !lk_hit); // R5
endmodule

// File: tb/vlan_member_table_tb_top.sv
`timescale 1ns/100ps
module vlan_member_table_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic        cfg_wr_sel;
  logic [31:0] cfg_wr_data;
  logic        cfg_rd_sel;
  logic [31:0] cfg_rd_data;
  logic [11:0] lk_vid;
  logic        lk_hit;
  logic [9:0]  lk_mask;

  vlan_member_table dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_sel  (cfg_wr_sel),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_sel  (cfg_rd_sel),
    .cfg_rd_data (cfg_rd_data),
    .lk_vid      (lk_vid),
    .lk_hit      (lk_hit),
    .lk_mask     (lk_mask)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // set-based reference model over identifiers 0..255
  bit       ref_val  [0:255];
  bit [9:0] ref_mask [0:255];
  bit       ref_full;
  bit       exp_found;
  int       exp_vid;
  bit [9:0] exp_mask;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_count();
    int c = 0;
    for (int v = 0; v < 256; v++) if (ref_val[v]) c++;
    return c;
  endfunction

  task automatic ref_apply(input logic [2:0] f, input int vid, input int port, input bit [9:0] m);
    case (f)
      3'd1: for (int v = 0; v < 256; v++) ref_val[v] = 0;
      3'd2: if (vid != 0) begin
        if (ref_val[vid]) ref_mask[vid] = m;
        else if (ref_count() < 16) begin ref_val[vid] = 1; ref_mask[vid] = m; end
        else ref_full = 1;
      end
      3'd3: ref_val[vid] = 0;
      3'd4: if (port < 10) begin
        for (int v = 0; v < 256; v++) if (ref_val[v]) begin
          ref_mask[v][port] = 1'b0;
          if (ref_mask[v] == 0) ref_val[v] = 0;
        end
      end
      3'd5: begin
        exp_found = 0; exp_vid = vid; exp_mask = 0;
        for (int v = 255; v > vid; v--) if (ref_val[v]) begin
          exp_found = 1; exp_vid = v; exp_mask = ref_mask[v];
        end
      end
      default: ;
    endcase
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic look(input string req, input int vid);
    lk_vid = 12'(vid);
    #1;
    check(req, {31'b0, lk_hit}, {31'b0, ref_val[vid]});
    check(req, {22'b0, lk_mask}, {22'b0, (ref_val[vid] ? ref_mask[vid] : 10'b0)});
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v <= 40; v++) look(req, v);
  endtask

  task automatic read_w(input logic sel, output logic [31:0] d);
    cfg_rd_sel = sel;
    #1;
    d = cfg_rd_data;
  endtask

  task automatic do_cmd(input logic [2:0] f, input int vid, input int port,
                        input bit [9:0] m, input bit intrude);
    logic [31:0] w0;
    logic [31:0] rd;
    string tag;
    w0 = {1'b1, 3'(vid % 8), 12'(vid), 4'b0, 4'(port), 3'b0, 1'b0, 1'b1, f};
    wr(1'b1, {20'b0, 1'b0, 1'b0, m});
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 1'b0; cfg_wr_data = w0;
    @(negedge clk);
    if (intrude) cfg_wr_data = 32'h00FF_0A0B;  // lands during busy: must be dropped
    else         cfg_wr_en = 1'b0;
    read_w(1'b0, rd);
    check("R2 busy set", {31'b0, rd[3]}, 32'd1);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    read_w(1'b0, rd);
    check("R2 busy clear", {31'b0, rd[3]}, 32'd0);
    ref_apply(f, vid, port, m);
    if (f != 3'd5) check("R2 fields kept", {16'b0, rd[31:16]}, {16'b0, w0[31:16]});
    check("R6 full flag", {31'b0, rd[4]}, {31'b0, ref_full});
    case (f)
      3'd1: tag = "R8";
      3'd2: tag = (vid == 0) ? "R5" : "R3";
      3'd3: tag = "R7";
      3'd4: tag = "R9";
      3'd5: tag = "R10";
      default: tag = "R11";
    endcase
    look(tag, vid);
    if (f == 3'd5) begin
      check("R10 vid", {20'b0, rd[27:16]}, 32'(exp_vid));
      read_w(1'b1, rd);
      check("R10 word1", rd, exp_found ? {20'b0, 1'b1, 1'b0, exp_mask} : 32'b0);
    end
  endtask

  initial begin
    logic [31:0] rd;
    cfg_wr_en = 0; cfg_wr_sel = 0; cfg_wr_data = 0; cfg_rd_sel = 0; lk_vid = 0;
    ref_full = 0;
    for (int v = 0; v < 256; v++) begin ref_val[v] = 0; ref_mask[v] = 0; end
    void'($urandom(32'd20240611));
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    read_w(1'b0, rd); check("R1 word0", rd, 32'b0);
    read_w(1'b1, rd); check("R1 word1", rd, 32'b0);
    sweep("R1");

    // R3 load, R2 intrusion
    do_cmd(3'd2, 100, 0, 10'h005, 0);
    lk_vid = 12'd100; #1;
    check("R3 mask", {22'b0, lk_mask}, 32'h005);
    do_cmd(3'd2, 7, 0, 10'h003, 1);
    read_w(1'b0, rd);
    check("R2 ignored vid", {20'b0, rd[27:16]}, 32'd7);
    // R5 identifier zero
    do_cmd(3'd2, 0, 0, 10'h3FF, 0);
    // R11 no-op with operands
    do_cmd(3'd0, 7, 2, 10'h000, 0);
    look("R11", 7);

    // R4 / R6 fill and overflow
    do_cmd(3'd1, 0, 0, 0, 0);
    for (int v = 1; v <= 16; v++) do_cmd(3'd2, v, 0, 10'(v), 0);
    do_cmd(3'd2, 17, 0, 10'h0AA, 0);
    read_w(1'b0, rd); check("R6 full set", {31'b0, rd[4]}, 32'd1);
    wr(1'b0, 32'h0001_0000);
    read_w(1'b0, rd); check("R6 full held", {31'b0, rd[4]}, 32'd1);
    wr(1'b0, 32'h0);
    ref_full = 0;
    read_w(1'b0, rd); check("R6 full cleared", {31'b0, rd[4]}, 32'd0);
    do_cmd(3'd2, 5, 0, 10'h3FF, 0);
    read_w(1'b0, rd); check("R4 replace no full", {31'b0, rd[4]}, 32'd0);
    sweep("R4");

    // R10 walk
    do_cmd(3'd5, 0, 0, 0, 0);
    do_cmd(3'd5, 9, 0, 0, 0);
    do_cmd(3'd5, 16, 0, 0, 0);

    // R9 port removal
    do_cmd(3'd1, 0, 0, 0, 0);
    do_cmd(3'd2, 20, 0, 10'h004, 0);
    do_cmd(3'd2, 21, 0, 10'h006, 0);
    do_cmd(3'd4, 0, 2, 0, 0);
    look("R9 emptied", 20);
    look("R9 trimmed", 21);
    do_cmd(3'd4, 0, 12, 0, 0);
    sweep("R9");
    // R7 purge
    do_cmd(3'd2, 22, 0, 10'h010, 0);
    do_cmd(3'd3, 21, 0, 0, 0);
    sweep("R7");
    // R8 flush
    do_cmd(3'd1, 0, 0, 0, 0);
    sweep("R8");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int r, vid, port;
      bit [9:0] m;
      r    = $urandom_range(0, 99);
      vid  = $urandom_range(0, 30);
      port = $urandom_range(0, 11);
      m    = 10'($urandom_range(0, 1023));
      if (r < 45)      do_cmd(3'd2, vid, port, m, 0);
      else if (r < 60) do_cmd(3'd3, vid, port, m, 0);
      else if (r < 75) do_cmd(3'd5, vid, port, m, 0);
      else if (r < 83) do_cmd(3'd4, vid, port, m, 0);
      else if (r < 85) do_cmd(3'd1, vid, port, m, 0);
      else if (r < 90) do_cmd(3'(6 + (r % 2)), vid, port, m, 0);
      else begin
        wr(1'b0, 32'h0);
        ref_full = 0;
        read_w(1'b0, rd); check("R6 clear", {31'b0, rd[4]}, 32'd0);
      end
      look("R3 random", $urandom_range(0, 30));
    end
    sweep("R3 final");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule